// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block is the digital control loop of a successive-approximation analog-to-digital converter. A start pulse begins a binary search over a WIDTH-bit code. Each trial cycle, the block drives a trial code to an external DAC. It then takes a one-bit answer from an external comparator on the clock edge that ends the cycle. That answer decides the bit under test. The search starts at the most significant bit and moves one position lower every cycle.

The conversion always takes WIDTH trial cycles, whatever the input level. After the final decision a done flag rises. The result is held until the next accepted start. The DAC, the comparator and the sample-and-hold are outside the block. The comparator input `cmp_i` is high when the held analog input is at or above the DAC level set by `trial_o`.

Top module: `sar_ctrl`

## Requirements
- R1: While reset is asserted, and after reset is released, `done_o` is 0, `trial_o` is 0 and `result_o` is 0. The asynchronous reset `rst_n` is active low.
- R2: A start is accepted at a clock edge where `start_i` is 1 and no conversion is running. In the cycle after that edge `trial_o` has only its most significant bit set, which is mid-scale.
- R3: At the edge that ends a trial cycle, the bit under test stays 1 if `cmp_i` is 1 and becomes 0 if `cmp_i` is 0. In the next cycle the next lower bit is set on top of the bits already decided.
- R4: A conversion has exactly WIDTH trial cycles for any input. `done_o` is 0 during those cycles and becomes 1 in the cycle after the edge that ends the last trial cycle.
- R5: Once a bit has been decided, it never changes again within that conversion.
- R6: When `done_o` is 1, `result_o` holds the decided code. When the comparator reports input >= trial, this code is the input level, clipped to 2^WIDTH-1. For example, with WIDTH=6 and input 38 the decisions are set, clear, clear, set, set, clear, and the result is 100110.
- R7: A start pulse that arrives while a conversion is running has no effect, even on the edge of the last decision.
- R8: `done_o` stays 1 and `result_o` stays stable, whatever `cmp_i` does, until the next start. A start while done is 1 clears `done_o` and begins a new conversion at once.
- R9: Outside the trial cycles `trial_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Conversion request, sampled on the rising clock edge |
| cmp_i | input | 1 | Comparator result: 1 when the analog input is at or above the DAC level |
| trial_o | output | WIDTH | Trial code driven to the DAC |
| result_o | output | WIDTH | Converted code, valid while done_o is 1 |
| done_o | output | 1 | Conversion complete flag |

## Verification
Two cases are hard to bring about from the ports. The first is a start that lands inside a running conversion, above all on the edge of the last decision, where the control returns to idle. The bench raises `start_i` in a chosen trial cycle, including the final one, and checks that every later trial code and the completion timing stay unchanged. The second is the hold after completion: the bench moves the modelled analog input around after done and checks that the result does not follow it. The comparator is modelled as an integer input compared against `trial_o`, so the levels 0, full scale and the powers of two either side of mid-scale can be driven directly.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } sar_state_e;
endpackage

// File: rtl/sar_rst_sync.sv
module sar_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_ns = sync_q;
endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer
  import sar_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_ns,
  input  logic             start_i,
  output logic             busy_o,
  output logic             load_o,
  output logic             finish_o,
  output logic [WIDTH-1:0] ptr_o
);
  localparam logic [WIDTH-1:0] MsbOne = WIDTH'(1) << (WIDTH - 1);

  sar_state_e       state_q, state_d;
  logic [WIDTH-1:0] ptr_q, ptr_d;
  logic             step_en;

  assign busy_o   = (state_q == ST_BUSY);
  assign load_o   = (state_q == ST_IDLE) && start_i;
  assign finish_o = busy_o && ptr_q[0];
  assign step_en  = load_o || busy_o;
  assign ptr_o    = ptr_q;

  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_q;
    if (load_o) begin
      state_d = ST_BUSY;
      ptr_d   = MsbOne;
    end else if (busy_o) begin
      ptr_d = ptr_q >> 1;
      if (ptr_q[0]) begin
        state_d = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
    end else if (step_en) begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
    end
  end

  // R2
  first_trial_msb_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(busy_o) |-> (ptr_q == MsbOne));

  // R7
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (busy_o && start_i && !ptr_q[0]) |=> (busy_o && (ptr_q == ($past(ptr_q) >> 1))));

  // R3
  ptr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    busy_o |-> ($countones(ptr_q) == 1));
endmodule

// File: rtl/sar_code_reg.sv
module sar_code_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_ns,
  input  logic             load_i,
  input  logic             busy_i,
  input  logic [WIDTH-1:0] ptr_i,
  input  logic             cmp_i,
  output logic [WIDTH-1:0] code_o
);
  logic [WIDTH-1:0] code_q, code_d;
  logic             code_en;

  assign code_en = load_i || busy_i;
  assign code_o  = code_q;

  always_comb begin
    code_d = code_q;
    if (load_i) begin
      code_d = '0;
    end else if (busy_i && cmp_i) begin
      code_d = code_q | ptr_i;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      code_q <= '0;
    end else if (code_en) begin
      code_q <= code_d;
    end
  end

  // R5
  decided_bits_frozen_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    busy_i |=> (((code_q ^ $past(code_q)) & ~$past(ptr_i)) == '0));

  // R3
  tested_bit_follows_cmp_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    busy_i |=> (((code_q & $past(ptr_i)) != '0) == $past(cmp_i)));
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cmp_i,
  output logic [WIDTH-1:0] trial_o,
  output logic [WIDTH-1:0] result_o,
  output logic             done_o
);
  localparam int CntW = $clog2(WIDTH + 1) + 1;

  logic             rst_ns;
  logic             busy;
  logic             load;
  logic             finish;
  logic [WIDTH-1:0] ptr;
  logic [WIDTH-1:0] code;
  logic             done_q, done_d;
  logic             done_en;

  sar_rst_sync u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  sar_sequencer #(.WIDTH(WIDTH)) u_seq (
    .clk      (clk),
    .rst_ns   (rst_ns),
    .start_i  (start_i),
    .busy_o   (busy),
    .load_o   (load),
    .finish_o (finish),
    .ptr_o    (ptr)
  );

  sar_code_reg #(.WIDTH(WIDTH)) u_code (
    .clk    (clk),
    .rst_ns (rst_ns),
    .load_i (load),
    .busy_i (busy),
    .ptr_i  (ptr),
    .cmp_i  (cmp_i),
    .code_o (code)
  );

  assign done_en = load || finish;

  always_comb begin
    done_d = done_q;
    if (load) begin
      done_d = 1'b0;
    end else if (finish) begin
      done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      done_q <= 1'b0;
    end else if (done_en) begin
      done_q <= done_d;
    end
  end

  assign trial_o  = busy ? (code | ptr) : '0;
  assign result_o = code;
  assign done_o   = done_q;

  logic [CntW-1:0] trial_cnt_q;
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      trial_cnt_q <= '0;
    end else if (load) begin
      trial_cnt_q <= '0;
    end else if (busy) begin
      trial_cnt_q <= trial_cnt_q + 1'b1;
    end
  end

  // R4
  trial_count_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(done_q) |-> (trial_cnt_q == CntW'(WIDTH)));

  // R4
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    finish |=> done_q);

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (done_q && !start_i) |=> (done_q && $stable(result_o)));

  // R9
  idle_trial_zero_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    !busy |-> (trial_o == '0));

  // R4
  no_done_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    busy |-> !done_q);
endmodule

// File: tb/sar_ctrl_tb.sv
`timescale 1ns/1ps
module sar_ctrl_tb;
  localparam int W    = 6;
  localparam int MAXV = (1 << W) - 1;

  logic         clk;
  logic         rst_n;
  logic         start;
  logic         cmp;
  logic [W-1:0] trial;
  logic [W-1:0] result;
  logic         done;

  int vin;
  int n_chk;
  int n_fail;
  int cyc;

  sar_ctrl #(.WIDTH(W)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start),
    .cmp_i    (cmp),
    .trial_o  (trial),
    .result_o (result),
    .done_o   (done)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // comparator model: input at or above the DAC level
  always_comb cmp = (vin >= int'(trial));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      summary();
      $finish;
    end
  end

  // Reference model: behavioural binary search run alongside the DUT.
  task automatic convert(input int v, input int intr_k);
    int acc;
    int expv;
    @(negedge clk);
    vin   = v;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    acc = 0;
    for (int k = 0; k < W; k++) begin
      expv = acc | (1 << (W - 1 - k));
      if (k == 0) check(int'(trial) == expv, "R2 first trial mid-scale", int'(trial), expv);
      else        check(int'(trial) == expv, "R3 trial code", int'(trial), expv);
      check(done == 1'b0, "R4 done low while converting", int'(done), 0);
      if (k == intr_k) start = 1'b1;
      if (v >= expv) acc = expv;
      @(negedge clk);
      start = 1'b0;
    end
    check(done == 1'b1, "R4 done after last decision", int'(done), 1);
    check(int'(result) == acc, "R6 result code", int'(result), acc);
    expv = (v > MAXV) ? MAXV : v;
    check(int'(result) == expv, "R6 result equals input", int'(result), expv);
    check(trial == '0, "R9 trial zero after conversion", int'(trial), 0);
  endtask

  initial begin
    int held;
    n_chk  = 0;
    n_fail = 0;
    cyc    = 0;
    vin    = 0;
    start  = 1'b0;
    rst_n  = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(done == 1'b0, "R1 done in reset", int'(done), 0);
    check(trial == '0, "R1 trial in reset", int'(trial), 0);
    check(result == '0, "R1 result in reset", int'(result), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(done == 1'b0, "R1 done after reset", int'(done), 0);
    check(trial == '0, "R9 trial idle", int'(trial), 0);

    // R6 worked example: 38 -> 100110
    convert(38, -1);
    check(int'(result) == 6'b100110, "R6 example code", int'(result), 6'b100110);

    convert(0, -1);
    convert(MAXV, -1);
    convert(MAXV + 20, -1);
    convert(1, -1);
    convert(32, -1);
    convert(31, -1);
    convert(21, -1);
    convert(42, -1);

    // R7 start during conversion, mid and on the last decision edge
    convert(45, 2);
    convert(19, 0);
    convert(50, W - 1);

    // R8 hold while the input moves
    held = int'(result);
    for (int i = 0; i < 6; i++) begin
      vin = (i * 11) % (MAXV + 1);
      @(negedge clk);
      check(done == 1'b1, "R8 done held", int'(done), 1);
      check(int'(result) == held, "R8 result held", int'(result), held);
      check(trial == '0, "R9 trial idle while done", int'(trial), 0);
    end

    // R8 back-to-back restart straight from done
    convert(7, -1);
    convert(56, -1);

    // R1 reset in the middle of a conversion
    @(negedge clk);
    vin   = 33;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(trial == '0, "R1 trial after mid reset", int'(trial), 0);
    check(done == 1'b0, "R1 done after mid reset", int'(done), 0);
    check(result == '0, "R1 result after mid reset", int'(result), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    convert(33, -1);

    summary();
    $finish;
  end
endmodule